// File: doc/BRIEF.md
# Tile Pixel Generator

This block turns character-cell video memory into a stream of 4-bit color indices, one pixel per clock. An external timing generator supplies a horizontal cycle counter and a line counter. A register block supplies the table base selectors, the mode bit, the display-enable bit and a screen color byte. The generator reads name, color and pattern bytes from a 16 KB byte-wide video memory through a single-port request/grant interface. It presents each pixel's color index together with a valid strobe.

Two cell layouts are supported. The first is a 32 x 24 grid of 8-pixel-wide cells, where each run of eight consecutive character codes shares one color byte. The second is a 40 x 24 grid of 6-pixel-wide cells, where both colors come from the screen color byte. The fetches for the next cell overlap the shifting out of the current one. The first cell of each line is fetched during a lead window of `LEAD` cycles at the start of the line, before the first visible pixel. Lines 192 and beyond show the backdrop color and cause no memory traffic.

Top module: `tile_pixel_gen`

## Requirements
- R1: With `textMode` = 0 a visible line carries 32 cells of 8 pixels. The name byte of cell c on line v is read at `nameSel`*1024 + (v/8)*32 + c.
- R2: With `textMode` = 0 the color byte is read at `colorSel`*64 + name/8. Its bits 7..4 are the foreground index and its bits 3..0 are the background index.
- R3: The pattern byte is read at `patSel`*2048 + name*8 + (v mod 8). Bit 7 is the leftmost pixel. A 1 shows the foreground index and a 0 shows the background index.
- R4: With `textMode` = 1 a visible line carries 40 cells of 6 pixels. The name byte is read at `nameSel`*1024 + (v/8)*40 + c. Pattern bits 7 down to 2 are shown left to right. The foreground is `screenColors`[7:4] and the background is `screenColors`[3:0].
- R5: With `dispOn` = 0 every valid pixel is index 0 and no memory request is raised.
- R6: On lines with `vPos` >= 192 every valid pixel is `screenColors`[3:0] and no memory request is raised.
- R7: `pixValid` is 1 in exactly the cycle after each cycle in which `hCount` lies in [`LEAD`, `LEAD` + line width). Pixel x is reported for `hCount` = `LEAD` + x. Whenever `pixValid` is 0, `pixColor` is 0.
- R8: Memory reads go only through `memReq`/`memGrant`. `memData` is valid in the cycle after a granted request. A refused request keeps `memReq` and `memAddr` steady until it is granted. On a line, a visible display makes exactly 3 granted reads per cell in the 8-pixel layout and 2 in the 6-pixel layout. Refusing the grant for the first three cycles of a line leaves the pixels unchanged.
- R9: While `rstN` is low, `pixValid`, `pixColor` and `memReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hCount | input | 10 | Horizontal cycle counter, 0 at line start |
| vPos | input | 9 | Line number |
| dispOn | input | 1 | Display enable |
| textMode | input | 1 | 1 selects 40-column 6-pixel cells |
| nameSel | input | 4 | Name table base in 1024-byte steps |
| colorSel | input | 8 | Color table base in 64-byte steps |
| patSel | input | 3 | Pattern table base in 2048-byte steps |
| screenColors | input | 8 | Text colors (7..4 fg, 3..0 bg); 3..0 is also the backdrop |
| memReq | output | 1 | Read request |
| memGrant | input | 1 | Read accepted this cycle |
| memAddr | output | 14 | Read byte address |
| memData | input | 8 | Read data, one cycle after grant |
| pixValid | output | 1 | Pixel strobe |
| pixColor | output | 4 | Pixel color index |

## Verification
The bench drives full frames in the 8-pixel layout with distinct table bases and varied memory contents. Here foreground/background swaps and wrong group division (name/8) show up as color errors. A full frame in the 6-pixel layout separates the row stride of 40 and the dropped low pattern bits from the 32-column case. Disabled lines and border lines check the two color overrides. Lines with the grant refused during the lead window confirm that request stalls neither lose fetches nor shift pixels, and per-line read counts catch extra or missing accesses.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int ADDR_W   = 14;
  localparam int DATA_W   = 8;
  localparam int COLOR_W  = 4;
  localparam int COL_W    = 6;
  localparam int SUB_W    = 3;
  localparam int GFX_COLS = 32;
  localparam int TXT_COLS = 40;
  localparam int GFX_CELL = 8;
  localparam int TXT_CELL = 6;
  localparam int NAME_SH  = 10;
  localparam int COLOR_SH = 6;
  localparam int PAT_SH   = 11;

  typedef enum logic [1:0] {
    SEL_NAME,
    SEL_COLOR,
    SEL_PAT
  } addrSel_e;

  typedef struct packed {
    addrSel_e          addrSel;
    logic [COL_W-1:0]  col;
    logic              latchName;
    logic              latchColor;
    logic              latchPat;
    logic              loadTile;
    logic              pixActive;
  } ctlStrobe_t;
endpackage

// File: rtl/tpg_fetch_ctrl.sv
module tpg_fetch_ctrl
  import tpg_pkg::*;
#(
  parameter int H_W  = 10,
  parameter int V_W  = 9,
  parameter int LEAD = 8,
  parameter int ROWS = 192
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [H_W-1:0] hCount,
  input  logic [V_W-1:0] vPos,
  input  logic           dispOn,
  input  logic           textMode,
  input  logic           memGrant,
  output logic           memReq,
  output logic           tileReady,
  output ctlStrobe_t     ctl
);
  localparam logic [H_W-1:0] LEAD_H  = H_W'(LEAD);
  localparam logic [H_W-1:0] GFX_END = H_W'(LEAD + GFX_COLS * GFX_CELL);
  localparam logic [H_W-1:0] TXT_END = H_W'(LEAD + TXT_COLS * TXT_CELL);
  localparam logic [V_W-1:0] ROW_LIM = V_W'(ROWS);

  typedef enum logic [2:0] {
    F_IDLE, F_NAME_RQ, F_NAME_WT, F_COLOR_RQ, F_PAT_RQ, F_PAT_WT, F_FULL
  } fetchState_e;

  fetchState_e      st;
  logic [COL_W-1:0] col;
  logic [SUB_W-1:0] sub;
  logic             colorPend;

  logic [H_W-1:0]   endH;
  logic [COL_W-1:0] lastCol;
  logic [SUB_W-1:0] lastSub;
  logic             lineStart;
  logic             rowLive;
  logic             pixActive;
  logic             loadTile;

  always_comb begin
    endH      = textMode ? TXT_END : GFX_END;
    lastCol   = textMode ? COL_W'(TXT_COLS - 1) : COL_W'(GFX_COLS - 1);
    lastSub   = textMode ? SUB_W'(TXT_CELL - 1) : SUB_W'(GFX_CELL - 1);
    lineStart = (hCount == '0);
    rowLive   = (vPos < ROW_LIM);
    pixActive = (hCount >= LEAD_H) && (hCount < endH);
    loadTile  = pixActive && (sub == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= F_IDLE;
      col       <= '0;
      sub       <= '0;
      colorPend <= 1'b0;
    end else begin
      colorPend <= (st == F_COLOR_RQ) && memGrant;
      if (!pixActive || sub == lastSub) sub <= '0;
      else sub <= sub + 1'b1;

      if (lineStart) begin
        col <= '0;
        st  <= (dispOn && rowLive) ? F_NAME_RQ : F_IDLE;
      end else begin
        unique case (st)
          F_NAME_RQ:  if (memGrant) st <= F_NAME_WT;
          F_NAME_WT:  st <= textMode ? F_PAT_RQ : F_COLOR_RQ;
          F_COLOR_RQ: if (memGrant) st <= F_PAT_RQ;
          F_PAT_RQ:   if (memGrant) st <= F_PAT_WT;
          F_PAT_WT:   st <= F_FULL;
          F_FULL: begin
            if (loadTile) begin
              if (col == lastCol) begin
                st <= F_IDLE;
              end else begin
                col <= col + 1'b1;
                st  <= F_NAME_RQ;
              end
            end
          end
          default: st <= F_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    memReq    = (st == F_NAME_RQ) || (st == F_COLOR_RQ) || (st == F_PAT_RQ);
    tileReady = (st == F_FULL);
    unique case (st)
      F_COLOR_RQ: ctl.addrSel = SEL_COLOR;
      F_PAT_RQ:   ctl.addrSel = SEL_PAT;
      default:    ctl.addrSel = SEL_NAME;
    endcase
    ctl.col        = col;
    ctl.latchName  = (st == F_NAME_WT);
    ctl.latchColor = colorPend;
    ctl.latchPat   = (st == F_PAT_WT);
    ctl.loadTile   = loadTile;
    ctl.pixActive  = pixActive;
  end
endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int V_W  = 9,
  parameter int ROWS = 192
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 ctl,
  input  logic [V_W-1:0]             vPos,
  input  logic                       dispOn,
  input  logic                       textMode,
  input  logic [ADDR_W-NAME_SH-1:0]  nameSel,
  input  logic [ADDR_W-COLOR_SH-1:0] colorSel,
  input  logic [ADDR_W-PAT_SH-1:0]   patSel,
  input  logic [DATA_W-1:0]          screenColors,
  input  logic [DATA_W-1:0]          memData,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       pixValid,
  output logic [COLOR_W-1:0]         pixColor
);
  localparam logic [V_W-1:0] ROW_LIM = V_W'(ROWS);

  logic [DATA_W-1:0]  nameReg, patNext, shReg;
  logic [COLOR_W-1:0] fgNext, bgNext, fgCur, bgCur;

  logic [ADDR_W-1:0]  rowWide, rowOff, nameAddr, colorAddr, patAddr;
  logic [COLOR_W-1:0] loadFg, loadBg, fgNow, bgNow, colorNext;
  logic               curBit;
  logic               rowLive;

  always_comb begin
    rowWide   = ADDR_W'(vPos[7:3]);
    rowOff    = textMode ? ((rowWide << 5) + (rowWide << 3)) : (rowWide << 5);
    nameAddr  = {nameSel, NAME_SH'(0)} + rowOff + ADDR_W'(ctl.col);
    colorAddr = {colorSel, COLOR_SH'(0)} + ADDR_W'(nameReg[DATA_W-1:3]);
    patAddr   = {patSel, PAT_SH'(0)} + (ADDR_W'(nameReg) << 3) + ADDR_W'(vPos[2:0]);
    unique case (ctl.addrSel)
      SEL_COLOR: memAddr = colorAddr;
      SEL_PAT:   memAddr = patAddr;
      default:   memAddr = nameAddr;
    endcase
  end

  always_comb begin
    rowLive = (vPos < ROW_LIM);
    loadFg  = textMode ? screenColors[7:4] : fgNext;
    loadBg  = textMode ? screenColors[3:0] : bgNext;
    curBit  = ctl.loadTile ? patNext[DATA_W-1] : shReg[DATA_W-1];
    fgNow   = ctl.loadTile ? loadFg : fgCur;
    bgNow   = ctl.loadTile ? loadBg : bgCur;
    if (!ctl.pixActive || !dispOn) colorNext = '0;
    else if (!rowLive)             colorNext = screenColors[3:0];
    else                           colorNext = curBit ? fgNow : bgNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nameReg  <= '0;
      patNext  <= '0;
      shReg    <= '0;
      fgNext   <= '0;
      bgNext   <= '0;
      fgCur    <= '0;
      bgCur    <= '0;
      pixValid <= 1'b0;
      pixColor <= '0;
    end else begin
      if (ctl.latchName)  nameReg <= memData;
      if (ctl.latchColor) {fgNext, bgNext} <= memData;
      if (ctl.latchPat)   patNext <= memData;
      if (ctl.loadTile) begin
        shReg <= patNext << 1;
        fgCur <= loadFg;
        bgCur <= loadBg;
      end else if (ctl.pixActive) begin
        shReg <= shReg << 1;
      end
      pixValid <= ctl.pixActive;
      pixColor <= colorNext;
    end
  end
endmodule

// File: rtl/tile_pixel_gen.sv
module tile_pixel_gen
  import tpg_pkg::*;
#(
  parameter int H_W  = 10,
  parameter int V_W  = 9,
  parameter int LEAD = 8,
  parameter int ROWS = 192
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [H_W-1:0]             hCount,
  input  logic [V_W-1:0]             vPos,
  input  logic                       dispOn,
  input  logic                       textMode,
  input  logic [ADDR_W-NAME_SH-1:0]  nameSel,
  input  logic [ADDR_W-COLOR_SH-1:0] colorSel,
  input  logic [ADDR_W-PAT_SH-1:0]   patSel,
  input  logic [DATA_W-1:0]          screenColors,
  output logic                       memReq,
  input  logic                       memGrant,
  output logic [ADDR_W-1:0]          memAddr,
  input  logic [DATA_W-1:0]          memData,
  output logic                       pixValid,
  output logic [COLOR_W-1:0]         pixColor
);
  ctlStrobe_t ctl;
  logic       tileReady;

  tpg_fetch_ctrl #(.H_W(H_W), .V_W(V_W), .LEAD(LEAD), .ROWS(ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vPos(vPos), .dispOn(dispOn),
    .textMode(textMode), .memGrant(memGrant), .memReq(memReq),
    .tileReady(tileReady), .ctl(ctl)
  );

  tpg_datapath #(.V_W(V_W), .ROWS(ROWS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vPos(vPos), .dispOn(dispOn),
    .textMode(textMode), .nameSel(nameSel), .colorSel(colorSel),
    .patSel(patSel), .screenColors(screenColors), .memData(memData),
    .memAddr(memAddr), .pixValid(pixValid), .pixColor(pixColor)
  );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
#(
  parameter int V_W  = 9,
  parameter int ROWS = 192
) (
  input logic               clk,
  input logic               rstN,
  input logic               dispOn,
  input logic [V_W-1:0]     vPos,
  input logic               memReq,
  input logic               memGrant,
  input logic [ADDR_W-1:0]  memAddr,
  input logic               pixValid,
  input logic [COLOR_W-1:0] pixColor,
  input logic               pixActive,
  input logic               loadTile,
  input logic               tileReady
);
  localparam logic [V_W-1:0] ROW_LIM = V_W'(ROWS);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGrant) |=> (memReq && $stable(memAddr)));

  assert_tile_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    (loadTile && dispOn && vPos < ROW_LIM) |-> tileReady);

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !dispOn |-> !memReq);

  assert_dark_pixel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !$past(dispOn)) |-> (pixColor == '0));

  assert_border_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (vPos >= ROW_LIM) |-> !memReq);

  assert_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    pixActive |=> pixValid);

  assert_blank_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> (pixColor == '0));
endmodule

bind tile_pixel_gen tpg_checker #(.V_W(V_W), .ROWS(ROWS)) u_chk (
  .clk(clk), .rstN(rstN), .dispOn(dispOn), .vPos(vPos), .memReq(memReq),
  .memGrant(memGrant), .memAddr(memAddr), .pixValid(pixValid),
  .pixColor(pixColor), .pixActive(ctl.pixActive), .loadTile(ctl.loadTile),
  .tileReady(tileReady)
);

// File: tb/tile_pixel_gen_bench.sv
module tile_pixel_gen_bench;
  localparam int LEAD = 8;
  localparam int LINE = 280;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] hCount = '0;
  logic [8:0] vPos = '0;
  logic       dispOn = 1'b0;
  logic       textMode = 1'b0;
  logic [3:0] nameSel = '0;
  logic [7:0] colorSel = '0;
  logic [2:0] patSel = '0;
  logic [7:0] screenColors = '0;
  logic       memReq;
  logic       memGrant;
  logic [13:0] memAddr;
  logic [7:0] memData = '0;
  logic       pixValid;
  logic [3:0] pixColor;
  logic       denyOn = 1'b0;

  int compared = 0;
  int mismatched = 0;
  int grantCnt = 0;
  bit havePrev = 0;
  int pH, pV, pNb, pCb, pPb, pTc;
  bit pOn, pTm;

  always #4 clk = ~clk;

  assign memGrant = !(denyOn && hCount < 10'd3);

  tile_pixel_gen u_tile_pixel_gen (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vPos(vPos), .dispOn(dispOn),
    .textMode(textMode), .nameSel(nameSel), .colorSel(colorSel),
    .patSel(patSel), .screenColors(screenColors), .memReq(memReq),
    .memGrant(memGrant), .memAddr(memAddr), .memData(memData),
    .pixValid(pixValid), .pixColor(pixColor)
  );

  function automatic int memByte(input int a);
    return ((a * 73) ^ ((a >> 5) * 29) ^ 8'hC3) & 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (memReq && memGrant) memData <= 8'(memByte(int'(memAddr)));
    if (rstN && memReq && memGrant) grantCnt <= grantCnt + 1;
  end

  // Reference pixel: valid flag, color index and the requirement it exercises.
  function automatic void expPix(input int h, input int v, input bit on, input bit tm,
                                 input int nb, input int cb, input int pb, input int tc,
                                 output bit ev, output int ec, output string tag);
    int w, px, cellW, col, bitPos, name, cbyte, pat, fg, bg;
    w = tm ? 240 : 256;
    if (h < LEAD || h >= LEAD + w) begin
      ev = 0; ec = 0; tag = "R7"; return;
    end
    ev = 1;
    px = h - LEAD;
    if (!on) begin ec = 0; tag = "R5"; return; end
    if (v >= 192) begin ec = tc & 15; tag = "R6"; return; end
    cellW  = tm ? 6 : 8;
    col    = px / cellW;
    bitPos = 7 - (px % cellW);
    if (tm) begin
      name = memByte((nb * 1024 + (v / 8) * 40 + col) & 16383);
      fg = (tc >> 4) & 15; bg = tc & 15; tag = "R4";
    end else begin
      name  = memByte((nb * 1024 + (v / 8) * 32 + col) & 16383);
      cbyte = memByte((cb * 64 + name / 8) & 16383);
      fg = (cbyte >> 4) & 15; bg = cbyte & 15; tag = "R1 R2 R3";
    end
    pat = memByte((pb * 2048 + name * 8 + (v % 8)) & 16383);
    ec = ((pat >> bitPos) & 1) != 0 ? fg : bg;
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic runLines(input int firstV, input int nLines);
    for (int ln = 0; ln < nLines; ln++) begin
      int startCnt, expReads, v;
      v = firstV + ln;
      startCnt = 0;
      for (int h = 0; h < LINE; h++) begin
        @(negedge clk);
        if (havePrev) begin
          bit ev; int ec; string tag;
          expPix(pH, pV, pOn, pTm, pNb, pCb, pPb, pTc, ev, ec, tag);
          compared++;
          if (pixValid !== ev || int'(pixColor) != ec) begin
            mismatched++;
            $display("FAIL %s line %0d h %0d: actual valid=%0b color=%0d expected valid=%0b color=%0d",
                     tag, pV, pH, pixValid, pixColor, ev, ec);
          end
        end
        if (h == 0) startCnt = grantCnt;
        if (h == LINE - 1) begin
          // R8 read count per line (R5/R6 lines expect zero)
          expReads = (dispOn && v < 192) ? (textMode ? 80 : 96) : 0;
          compared++;
          if (grantCnt - startCnt != expReads) begin
            mismatched++;
            $display("FAIL R8 line %0d read count: actual %0d expected %0d",
                     v, grantCnt - startCnt, expReads);
          end
        end
        pH = h; pV = v; pOn = dispOn; pTm = textMode;
        pNb = int'(nameSel); pCb = int'(colorSel); pPb = int'(patSel); pTc = int'(screenColors);
        hCount = 10'(h);
        vPos = 9'(v);
        havePrev = 1;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL R7 watchdog: actual run not finished expected finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    hCount = 10'(LINE - 1);
    dispOn = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    compared++;
    if (pixValid !== 1'b0 || pixColor !== 4'd0 || memReq !== 1'b0) begin
      mismatched++;
      $display("FAIL R9 reset: actual valid=%0b color=%0d req=%0b expected 0 0 0",
               pixValid, pixColor, memReq);
    end
    rstN = 1'b1;

    // R1 R2 R3: 8-pixel cells, full frame plus border rows
    textMode = 0; nameSel = 4'd1; colorSel = 8'h20; patSel = 3'd2; screenColors = 8'h4A;
    runLines(0, 200);

    // R4: 6-pixel cells with grant refused in the lead window (R8)
    textMode = 1; nameSel = 4'd3; patSel = 3'd1; screenColors = 8'hE5; denyOn = 1;
    runLines(0, 200);

    // R5: display off
    dispOn = 0;
    runLines(100, 3);

    // R6 border rows, R8 stalls, top-end table bases
    dispOn = 1; textMode = 0; nameSel = 4'd15; colorSel = 8'hFF; patSel = 3'd7;
    screenColors = 8'h31;
    runLines(184, 12);

    // R1 R2 R3 with zero bases, no stalls
    denyOn = 0; nameSel = 4'd0; colorSel = 8'h00; patSel = 3'd0;
    runLines(0, 40);

    finishRun();
  end
endmodule